// File: doc/BRIEF.md
# Audio Matrix Control Register Slave

This block is a write-only two-wire serial bus slave that loads the four control registers of an audio matrix: effect mode, space attenuation, center attenuation and input attenuation. It runs on a fast system clock. It brings the bus clock and data lines through synchronizers and a short glitch filter, and it finds START and STOP conditions on the cleaned lines. After a matching device address it takes a subaddress byte and then data bytes. It acknowledges each byte it accepts by pulling the data line low.

The subaddress picks the first register to write and can turn on auto-increment. Without auto-increment every data byte lands in the same register. With auto-increment each later byte goes to the next index. Once the index leaves the register range, bytes are still acknowledged but are thrown away. Alongside the raw register values, the block outputs decoded fields: effect on and stereo flags, a mute flag for each attenuator, and each attenuation as a count of its own step size.

Top module: `amx_ctl_slave`

## Requirements
- R1: A START is the data line falling while the clock line is high, and a STOP is the data line rising while the clock line is high. A STOP ends the transfer and releases the data line. Bytes clocked after a STOP and before the next START are neither acknowledged nor written.
- R2: Each accepted byte (matching address, subaddress, or data) is acknowledged by holding the data line low through the ninth clock pulse. The line is released after that pulse. Bytes are 8 bits, MSB first.
- R3: The address byte is accepted only when it equals 0x80 with `strap` low, or 0x82 with `strap` high. Any other value, including a read request (LSB 1), is not acknowledged, and all following bytes are ignored until the next START or STOP.
- R4: In the subaddress byte, bits 1:0 select the register: 0 is mode, 1 is space, 2 is center and 3 is input attenuation. Bits 6:2 have no effect, and bit 7 set turns on auto-increment.
- R5: With auto-increment off, every data byte up to the STOP or restart is written to the selected register.
- R6: With auto-increment on, data bytes go to consecutive indexes starting from the selected one. Bytes at index 4 or higher are acknowledged but change no register.
- R7: After reset the registers hold mode 0x00, space 0x20, center 0x20 and input 0x40.
- R8: `fx_on` equals mode bit 0, and `fx_stereo` is 1 only when mode bits 0 and 1 are both 1.
- R9: `input_mute` equals input bit 6. `input_att` equals bits 5:3 times 8 plus bits 2:0, in half-decibel steps.
- R10: `space_mute` and `center_mute` equal bit 5 of their registers. `space_att` and `center_att` equal bits 4:3 times 8 plus bits 2:0, in 1 dB steps.
- R11: A START in the middle of a transfer returns the slave to the address phase, whatever state it was in.
- R12: A pulse on the bus clock line that lasts one system clock is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap | input | 1 | Selects address 0x82 when high, 0x80 when low |
| scl_in | input | 1 | Bus clock line as seen on the pin |
| sda_in | input | 1 | Bus data line as seen on the pin |
| sda_oe | output | 1 | 1 pulls the data line low (acknowledge) |
| mode_reg | output | 8 | Effect mode register |
| space_reg | output | 8 | Space attenuation register |
| center_reg | output | 8 | Center attenuation register |
| input_reg | output | 8 | Input attenuation register |
| fx_on | output | 1 | Effect enabled |
| fx_stereo | output | 1 | Effect enabled in stereo form |
| input_mute | output | 1 | Input attenuator at mute |
| space_mute | output | 1 | Space attenuator at mute |
| center_mute | output | 1 | Center attenuator at mute |
| input_att | output | 6 | Input attenuation in half-decibel steps |
| space_att | output | 5 | Space attenuation in 1 dB steps |
| center_att | output | 5 | Center attenuation in 1 dB steps |

## Verification
If the bit counter or the phase is wrong, the fault shows on `sda_oe` at the ninth clock pulse of the very byte concerned: an acknowledge is missing or stray. A wrong write index or a wrong auto-increment state shows as a wrong register value, or as a changed register that should have held. This appears within a few system clocks after the falling clock edge that ends that data byte. Faults in the filter or edge detection show up as a shifted byte value, or as a transfer that never begins, already in the address byte.

// File: rtl/amx_ctl_pkg.sv
package amx_ctl_pkg;
  localparam int REG_W   = 8;
  localparam int NREG    = 4;
  localparam int SEL_W   = $clog2(NREG);
  localparam int PTR_W   = 4;
  localparam int IN_F_W  = 6;
  localparam int FX_F_W  = 5;

  localparam int IDX_MODE   = 0;
  localparam int IDX_SPACE  = 1;
  localparam int IDX_CENTER = 2;
  localparam int IDX_INPUT  = 3;

  localparam logic [5:0] DEV_ADDR_HI = 6'b100000;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ADDR, PH_SUB, PH_DATA, PH_SKIP
  } phase_t;

  function automatic logic [REG_W-1:0] rst_val(input int idx);
    case (idx)
      IDX_MODE:   rst_val = 8'h00;
      IDX_SPACE:  rst_val = 8'h20;
      IDX_CENTER: rst_val = 8'h20;
      default:    rst_val = 8'h40;
    endcase
  endfunction

  // coarse field counts 8 fine steps
  function automatic logic [IN_F_W-1:0] in_steps(input logic [IN_F_W-1:0] f);
    in_steps = IN_F_W'(f[5:3]) * IN_F_W'(8) + IN_F_W'(f[2:0]);
  endfunction

  function automatic logic [FX_F_W-1:0] fx_steps(input logic [FX_F_W-1:0] f);
    fx_steps = FX_F_W'(f[4:3]) * FX_F_W'(8) + FX_F_W'(f[2:0]);
  endfunction
endpackage

// File: rtl/amx_line_filter.sv
module amx_line_filter #(
  parameter int SYNC  = 2,
  parameter int DEPTH = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic clean
);
  logic [SYNC-1:0]  sync_q;
  logic [DEPTH-1:0] hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      hist_q <= '1;
      clean  <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC-2:0], raw};
      hist_q <= {hist_q[DEPTH-2:0], sync_q[SYNC-1]};
      if (&hist_q)
        clean <= 1'b1;
      else if (~|hist_q)
        clean <= 1'b0;
    end
  end
endmodule

// File: rtl/amx_bus_fsm.sv
module amx_bus_fsm
  import amx_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl,
  input  logic             sda,
  input  logic             strap,
  output logic             sda_oe,
  output logic             start_evt,
  output logic             stop_evt,
  output logic             wr_en,
  output logic [SEL_W-1:0] wr_idx,
  output logic [REG_W-1:0] wr_data
);
  localparam int CNT_W = $clog2(REG_W + 1);

  phase_t           phase_q;
  logic             scl_q, sda_q;
  logic [REG_W-1:0] shreg_q;
  logic [CNT_W-1:0] bit_cnt_q;
  logic             ack_ph_q;
  logic             autoinc_q;
  logic [PTR_W-1:0] idx_q;

  logic scl_rise, scl_fall, byte_done, active, addr_ok, idx_in_range;

  assign scl_rise     = scl & ~scl_q;
  assign scl_fall     = ~scl & scl_q;
  assign start_evt    = scl & scl_q & sda_q & ~sda;
  assign stop_evt     = scl & scl_q & ~sda_q & sda;
  assign active       = (phase_q != PH_IDLE) && (phase_q != PH_SKIP);
  assign byte_done    = active && scl_fall && !ack_ph_q && (bit_cnt_q == CNT_W'(REG_W));
  assign addr_ok      = shreg_q == {DEV_ADDR_HI, strap, 1'b0};
  assign idx_in_range = idx_q[PTR_W-1:SEL_W] == '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q     <= 1'b1;
      sda_q     <= 1'b1;
      phase_q   <= PH_IDLE;
      shreg_q   <= '0;
      bit_cnt_q <= '0;
      ack_ph_q  <= 1'b0;
      autoinc_q <= 1'b0;
      idx_q     <= '0;
      sda_oe    <= 1'b0;
      wr_en     <= 1'b0;
      wr_idx    <= '0;
      wr_data   <= '0;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
      wr_en <= 1'b0;
      if (start_evt) begin
        phase_q   <= PH_ADDR;
        bit_cnt_q <= '0;
        ack_ph_q  <= 1'b0;
        sda_oe    <= 1'b0;
      end else if (stop_evt) begin
        phase_q   <= PH_IDLE;
        bit_cnt_q <= '0;
        ack_ph_q  <= 1'b0;
        sda_oe    <= 1'b0;
      end else if (active) begin
        if (scl_rise && !ack_ph_q && (bit_cnt_q < CNT_W'(REG_W))) begin
          shreg_q   <= {shreg_q[REG_W-2:0], sda};
          bit_cnt_q <= bit_cnt_q + 1'b1;
        end
        if (byte_done) begin
          ack_ph_q <= 1'b1;
          case (phase_q)
            PH_ADDR: begin
              if (addr_ok) begin
                sda_oe  <= 1'b1;
                phase_q <= PH_SUB;
              end else begin
                phase_q <= PH_SKIP;
              end
            end
            PH_SUB: begin
              sda_oe    <= 1'b1;
              autoinc_q <= shreg_q[REG_W-1];
              idx_q     <= PTR_W'(shreg_q[SEL_W-1:0]);
              phase_q   <= PH_DATA;
            end
            default: begin
              sda_oe <= 1'b1;
              if (idx_in_range) begin
                wr_en   <= 1'b1;
                wr_idx  <= idx_q[SEL_W-1:0];
                wr_data <= shreg_q;
              end
              if (autoinc_q && (idx_q != '1))
                idx_q <= idx_q + 1'b1;
            end
          endcase
        end else if (scl_fall && ack_ph_q) begin
          ack_ph_q  <= 1'b0;
          sda_oe    <= 1'b0;
          bit_cnt_q <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/amx_reg_bank.sv
module amx_reg_bank
  import amx_ctl_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [SEL_W-1:0]           wr_idx,
  input  logic [REG_W-1:0]           wr_data,
  output logic [NREG-1:0][REG_W-1:0] regs
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs[g] <= rst_val(g);
      else if (wr_en && (wr_idx == SEL_W'(g)))
        regs[g] <= wr_data;
    end
  end
endmodule

// File: rtl/amx_ctl_slave.sv
module amx_ctl_slave
  import amx_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_oe,
  output logic [REG_W-1:0]  mode_reg,
  output logic [REG_W-1:0]  space_reg,
  output logic [REG_W-1:0]  center_reg,
  output logic [REG_W-1:0]  input_reg,
  output logic              fx_on,
  output logic              fx_stereo,
  output logic              input_mute,
  output logic              space_mute,
  output logic              center_mute,
  output logic [IN_F_W-1:0] input_att,
  output logic [FX_F_W-1:0] space_att,
  output logic [FX_F_W-1:0] center_att
);
  localparam int NLINE = 2;

  logic [NLINE-1:0] raw_v, clean_v;
  logic scl_f, sda_f;
  logic start_evt, stop_evt, wr_en;
  logic [SEL_W-1:0] wr_idx;
  logic [REG_W-1:0] wr_data;
  logic [NREG-1:0][REG_W-1:0] regs;

  assign raw_v = {sda_in, scl_in};
  for (genvar g = 0; g < NLINE; g++) begin : g_line
    amx_line_filter #(.SYNC(2), .DEPTH(3)) u_filt (
      .clk(clk), .rst_n(rst_n), .raw(raw_v[g]), .clean(clean_v[g])
    );
  end
  assign scl_f = clean_v[0];
  assign sda_f = clean_v[1];

  amx_bus_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .scl(scl_f), .sda(sda_f), .strap(strap),
    .sda_oe(sda_oe), .start_evt(start_evt), .stop_evt(stop_evt),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  amx_reg_bank u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .regs(regs)
  );

  assign mode_reg    = regs[IDX_MODE];
  assign space_reg   = regs[IDX_SPACE];
  assign center_reg  = regs[IDX_CENTER];
  assign input_reg   = regs[IDX_INPUT];

  assign fx_on       = mode_reg[0];
  assign fx_stereo   = mode_reg[0] & mode_reg[1];
  assign input_mute  = input_reg[6];
  assign space_mute  = space_reg[5];
  assign center_mute = center_reg[5];
  assign input_att   = in_steps(input_reg[IN_F_W-1:0]);
  assign space_att   = fx_steps(space_reg[FX_F_W-1:0]);
  assign center_att  = fx_steps(center_reg[FX_F_W-1:0]);
endmodule

// File: rtl/amx_ctl_chk.sv
module amx_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_f,
  input logic       sda_oe,
  input logic       stop_evt,
  input logic       wr_en,
  input logic [7:0] mode_reg,
  input logic [7:0] space_reg,
  input logic [7:0] center_reg,
  input logic [7:0] input_reg
);
  AST_RESET_VALUES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (mode_reg == 8'h00 && space_reg == 8'h20 &&
                      center_reg == 8'h20 && input_reg == 8'h40)); // R7

  AST_REGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable({mode_reg, space_reg, center_reg, input_reg})); // R6

  AST_ONE_WRITE_PER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en); // R5

  AST_ACK_WHILE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_f); // R2

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_oe); // R1
endmodule

bind amx_ctl_slave amx_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_oe(sda_oe),
  .stop_evt(stop_evt), .wr_en(wr_en), .mode_reg(mode_reg),
  .space_reg(space_reg), .center_reg(center_reg), .input_reg(input_reg)
);

// File: tb/amx_ctl_slave_bench.sv
module amx_ctl_slave_bench;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic [7:0] mode_reg, space_reg, center_reg, input_reg;
  logic fx_on, fx_stereo, input_mute, space_mute, center_mute;
  logic [5:0] input_att;
  logic [4:0] space_att, center_att;
  wire sda_line = sda_m & ~sda_oe;

  always #4 clk = ~clk;

  amx_ctl_slave u_amx_ctl_slave (
    .clk(clk), .rst_n(rst_n), .strap(strap), .scl_in(scl_m), .sda_in(sda_line),
    .sda_oe(sda_oe), .mode_reg(mode_reg), .space_reg(space_reg),
    .center_reg(center_reg), .input_reg(input_reg), .fx_on(fx_on),
    .fx_stereo(fx_stereo), .input_mute(input_mute), .space_mute(space_mute),
    .center_mute(center_mute), .input_att(input_att), .space_att(space_att),
    .center_att(center_att)
  );

  int checks = 0;
  int errors = 0;

  typedef struct {
    string          tag;
    logic [3:0][7:0] r;
  } exp_t;
  exp_t exp_q[$];
  logic [3:0][7:0] model;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic push_expect(input string tag);
    exp_t e;
    wait_clk(12);
    e.tag = tag;
    e.r = model;
    exp_q.push_back(e);
  endtask

  // monitor: pops expected register snapshots and compares every output
  initial begin
    forever begin
      exp_t e;
      int ia, sa, ca;
      wait (exp_q.size() > 0);
      @(negedge clk);
      e = exp_q.pop_front();
      chk(mode_reg == e.r[0], {e.tag, " mode_reg"}, mode_reg, e.r[0]);
      chk(space_reg == e.r[1], {e.tag, " space_reg"}, space_reg, e.r[1]);
      chk(center_reg == e.r[2], {e.tag, " center_reg"}, center_reg, e.r[2]);
      chk(input_reg == e.r[3], {e.tag, " input_reg"}, input_reg, e.r[3]);
      chk(fx_on == e.r[0][0], {e.tag, " R8 fx_on"}, fx_on, e.r[0][0]);
      chk(fx_stereo == (e.r[0][0] && e.r[0][1]), {e.tag, " R8 fx_stereo"},
          fx_stereo, e.r[0][0] && e.r[0][1]);
      ia = ((int'(e.r[3]) / 8) % 8) * 8 + int'(e.r[3]) % 8;
      sa = ((int'(e.r[1]) / 8) % 4) * 8 + int'(e.r[1]) % 8;
      ca = ((int'(e.r[2]) / 8) % 4) * 8 + int'(e.r[2]) % 8;
      chk(input_mute == e.r[3][6], {e.tag, " R9 input_mute"}, input_mute, e.r[3][6]);
      chk(int'(input_att) == ia, {e.tag, " R9 input_att"}, input_att, ia);
      chk(space_mute == e.r[1][5], {e.tag, " R10 space_mute"}, space_mute, e.r[1][5]);
      chk(center_mute == e.r[2][5], {e.tag, " R10 center_mute"}, center_mute, e.r[2][5]);
      chk(int'(space_att) == sa, {e.tag, " R10 space_att"}, space_att, sa);
      chk(int'(center_att) == ca, {e.tag, " R10 center_att"}, center_att, ca);
    end
  end

  task automatic i_start();
    sda_m = 1'b1; wait_clk(Q);
    scl_m = 1'b1; wait_clk(Q);
    sda_m = 1'b0; wait_clk(Q);
    scl_m = 1'b0; wait_clk(Q);
  endtask

  task automatic i_stop();
    sda_m = 1'b0; wait_clk(Q);
    scl_m = 1'b1; wait_clk(Q);
    sda_m = 1'b1; wait_clk(Q);
  endtask

  task automatic i_byte(input logic [7:0] b, input bit exp_ack, input string tag,
                        input bit glitch = 1'b0);
    bit acked;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wait_clk(Q);
      scl_m = 1'b1;
      if (glitch && i == 4) begin
        wait_clk(Q / 2);
        scl_m = 1'b0; wait_clk(1);
        scl_m = 1'b1; wait_clk(Q / 2 - 1);
      end else begin
        wait_clk(Q);
      end
      scl_m = 1'b0; wait_clk(Q);
    end
    sda_m = 1'b1; wait_clk(Q);
    scl_m = 1'b1; wait_clk(Q / 2);
    acked = (sda_line == 1'b0);
    chk(acked == exp_ack, {tag, " ack"}, acked, exp_ack);
    wait_clk(Q / 2);
    scl_m = 1'b0; wait_clk(Q);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model[0] = 8'h00; model[1] = 8'h20; model[2] = 8'h20; model[3] = 8'h40;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(3);
    chk(sda_oe == 1'b0, "R7 sda released after reset", sda_oe, 0);
    push_expect("R7 reset state");

    // R3 R4 R8: strap low, mode register, stereo effect
    i_start();
    i_byte(8'h80, 1, "R3 addr 0x80");
    i_byte(8'h00, 1, "R4 sub mode");
    i_byte(8'h03, 1, "R2 data");
    i_stop();
    model[0] = 8'h03;
    push_expect("R8 stereo effect");

    // R5 R9: no auto-increment, two bytes into input
    i_start();
    i_byte(8'h80, 1, "R3 addr");
    i_byte(8'h03, 1, "R4 sub input");
    i_byte(8'h15, 1, "R5 data1");
    i_byte(8'h2A, 1, "R5 data2");
    i_stop();
    model[3] = 8'h2A;
    push_expect("R5 same register");

    // R4: bits 6:2 of subaddress have no effect
    i_start();
    i_byte(8'h80, 1, "R3 addr");
    i_byte(8'h7D, 1, "R4 sub junk bits");
    i_byte(8'h1B, 1, "R4 data");
    i_stop();
    model[1] = 8'h1B;
    push_expect("R4 space via junk subaddress");

    // R6: auto-increment from space, overflow discarded but acked
    i_start();
    i_byte(8'h80, 1, "R3 addr");
    i_byte(8'h81, 1, "R6 sub inc space");
    i_byte(8'h05, 1, "R6 space");
    i_byte(8'h3F, 1, "R6 center");
    i_byte(8'h47, 1, "R6 input");
    i_byte(8'hAA, 1, "R6 past end 1");
    i_byte(8'h55, 1, "R6 past end 2");
    i_stop();
    model[1] = 8'h05; model[2] = 8'h3F; model[3] = 8'h47;
    push_expect("R6 auto-increment");

    // R6: start at input, next byte discarded
    i_start();
    i_byte(8'h80, 1, "R3 addr");
    i_byte(8'h83, 1, "R6 sub inc input");
    i_byte(8'h08, 1, "R6 input");
    i_byte(8'h33, 1, "R6 discard");
    i_stop();
    model[3] = 8'h08;
    push_expect("R6 start at last index");

    // R3: wrong address, read request
    i_start();
    i_byte(8'h82, 0, "R3 0x82 with strap low");
    i_byte(8'h00, 0, "R3 ignored sub");
    i_byte(8'h07, 0, "R3 ignored data");
    i_stop();
    i_start();
    i_byte(8'h81, 0, "R3 read request");
    i_byte(8'h00, 0, "R3 ignored sub");
    i_stop();
    push_expect("R3 mismatch no write");

    // R3 with strap high, R11 restart after mismatch
    strap = 1'b1;
    wait_clk(Q);
    i_start();
    i_byte(8'h80, 0, "R3 0x80 with strap high");
    i_byte(8'h02, 0, "R3 ignored");
    i_start();
    i_byte(8'h82, 1, "R11 addr after restart");
    i_byte(8'h02, 1, "R4 sub center");
    i_byte(8'h00, 1, "R11 data");
    i_stop();
    model[2] = 8'h00;
    push_expect("R11 restart after mismatch");

    // R11: restart mid-data, then R8 mono decode
    i_start();
    i_byte(8'h82, 1, "R3 addr");
    i_byte(8'h00, 1, "R4 sub mode");
    i_byte(8'h01, 1, "R8 mono");
    i_start();
    i_byte(8'h82, 1, "R11 addr");
    i_byte(8'h03, 1, "R11 sub input");
    i_byte(8'h10, 1, "R11 data");
    i_stop();
    model[0] = 8'h01; model[3] = 8'h10;
    push_expect("R11 restart mid-data");

    // R1: bytes after STOP without START
    i_byte(8'h82, 0, "R1 no start addr");
    i_byte(8'h00, 0, "R1 no start sub");
    i_byte(8'h02, 0, "R1 no start data");
    i_stop();
    push_expect("R1 ignored after stop");

    // R12: one-clock glitch on clock line, R8 stereo bit alone
    i_start();
    i_byte(8'h82, 1, "R12 addr glitch", 1'b1);
    i_byte(8'h00, 1, "R12 sub glitch", 1'b1);
    i_byte(8'h02, 1, "R12 data glitch", 1'b1);
    i_stop();
    model[0] = 8'h02;
    push_expect("R12 glitch rejected");

    wait (exp_q.size() == 0);
    wait_clk(4);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule